// File: doc/BRIEF.md
# Level-0 Trigger Class Decision Unit

On every bunch crossing this block compares a 24-bit vector of level-0 input bits against a table of programmable trigger classes. A class is defined by two masks: one lists inputs that must be high and the other lists inputs that must be low. Each class also names the detector cluster it belongs to. The block registers two results. The first is the vector of classes that fired. The second is a one-cycle level-0 accept pulse for each cluster.

Each cluster is vetoed independently. A class is suppressed when its cluster reports busy, when that cluster's pile-up protection flag rejects the crossing, or when that cluster is still inside the fixed dead time that follows its previous accept. One input pattern can therefore trigger some clusters while the others stay blocked. Class definitions are loaded through a small write port. A write is dropped while any dead-time counter is running, so the table never changes while a decision is in progress.

Top module: `l0_class_gate`

## Requirements
- R1: After reset, `class_fired` and `clust_l0` are zero and every class is disabled, so an all-ones input pattern fires nothing.
- R2: A class fires in the cycle after the inputs are sampled when all of its required bits are 1, all of its forbidden bits are 0, and its cluster is not vetoed.
- R3: A class whose required mask and forbidden mask are both zero never fires.
- R4: While `clust_busy[c]` is high, no class assigned to cluster c fires and `clust_l0[c]` stays low. Other clusters are unaffected.
- R5: While `pf_reject[c]` is high, no class assigned to cluster c fires and `clust_l0[c]` stays low.
- R6: `clust_l0[c]` is the OR of the fired classes assigned to cluster c, registered in the same cycle as `class_fired`.
- R7: After a pulse on `clust_l0[c]`, that cluster stays blocked for the next DEAD_CYC-1 crossings (79 at the default). The earliest next accept comes exactly DEAD_CYC (80) crossings after the first.
- R8: Dead time is counted per cluster. A cluster that is not counting can accept while another cluster is dead.
- R9: Configuration writes use `cfg_sel` 0 for the required mask, 1 for the forbidden mask, 2 for the cluster index (taken from the low bits of `cfg_wdata`), and 3 for no effect. A write is ignored if any cluster's dead-time counter is running. Otherwise it takes effect from the next crossing.
- R10: A class whose cluster index is N_CLUST or larger (for example 7) never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| l0_in | input | 24 | Level-0 trigger input bits for the current crossing |
| clust_busy | input | 6 | Busy flag for each cluster |
| pf_reject | input | 6 | Pile-up protection reject flag for each cluster |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Class index being written |
| cfg_sel | input | 2 | Field select: 0 required, 1 forbidden, 2 cluster, 3 none |
| cfg_wdata | input | 24 | Mask or cluster index to write |
| class_fired | output | 50 | Registered vector of classes that fired |
| clust_l0 | output | 6 | Registered one-cycle level-0 accept pulse per cluster |

## Verification
Inputs and veto flags driven before a clock edge are reflected in `class_fired` and `clust_l0` right after that edge, so every decision is due one cycle after its stimulus. The bench drives on the falling edge and reads the outputs on the following falling edge. For dead time it counts crossings from the falling edge that sampled the first accept and expects the second accept at exactly crossing 80. A configuration write alters decisions starting one cycle later, so the bench always issues writes and then idles at least one cycle before applying a pattern. It also idles past the dead time between scenarios so that no scenario inherits blocking from the one before.

// File: rtl/l0cg_pkg.sv
package l0cg_pkg;
  typedef enum logic [1:0] {
    CFG_REQ  = 2'd0,
    CFG_FORB = 2'd1,
    CFG_CLU  = 2'd2,
    CFG_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/l0cg_class_table.sv
module l0cg_class_table
  import l0cg_pkg::*;
#(
  parameter int N_IN    = 24,
  parameter int N_CLASS = 50,
  parameter int N_CLUST = 6,
  localparam int CIW = $clog2(N_CLASS),
  localparam int CLW = $clog2(N_CLUST)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [CIW-1:0]                   wr_addr,
  input  cfg_sel_e                         wr_sel,
  input  logic [N_IN-1:0]                  wr_data,
  input  logic [N_IN-1:0]                  trig_in,
  output logic [N_CLASS-1:0]               match,
  output logic [N_CLASS-1:0][N_CLUST-1:0]  route
);
  for (genvar i = 0; i < N_CLASS; i++) begin : g_cls
    logic [N_IN-1:0] req_q, req_d, forb_q, forb_d;
    logic [CLW-1:0]  clu_q, clu_d;
    logic            hit;

    assign hit = wr_en && (wr_addr == CIW'(i));

    always_comb begin
      req_d  = req_q;
      forb_d = forb_q;
      clu_d  = clu_q;
      if (hit) begin
        case (wr_sel)
          CFG_REQ:  req_d  = wr_data;
          CFG_FORB: forb_d = wr_data;
          CFG_CLU:  clu_d  = wr_data[CLW-1:0];
          default:  ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q  <= '0;
        forb_q <= '0;
        clu_q  <= '0;
      end else if (hit) begin
        req_q  <= req_d;
        forb_q <= forb_d;
        clu_q  <= clu_d;
      end
    end

    assign match[i] = ((trig_in & req_q) == req_q) && ((trig_in & forb_q) == '0)
                      && ((req_q | forb_q) != '0);

    for (genvar c = 0; c < N_CLUST; c++) begin : g_rt
      assign route[i][c] = (clu_q == CLW'(c));
    end
  end
endmodule

// File: rtl/l0cg_deadtime.sv
module l0cg_deadtime #(
  parameter int N_CLUST  = 6,
  parameter int DEAD_CYC = 80,
  localparam int CNTW = $clog2(DEAD_CYC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CLUST-1:0] fire,
  output logic [N_CLUST-1:0] dead,
  output logic               any_dead
);
  for (genvar c = 0; c < N_CLUST; c++) begin : g_ctr
    logic [CNTW-1:0] cnt_q, cnt_d;

    always_comb begin
      cnt_d = cnt_q;
      if (fire[c])            cnt_d = CNTW'(DEAD_CYC - 1);
      else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign dead[c] = (cnt_q != '0);

    // R7: the decision logic must never accept while this counter is running
    p_no_fire_in_dead_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dead[c] |-> !fire[c]);
  end

  assign any_dead = |dead;
endmodule

// File: rtl/l0_class_gate.sv
module l0_class_gate
  import l0cg_pkg::*;
#(
  parameter int N_IN     = 24,
  parameter int N_CLASS  = 50,
  parameter int N_CLUST  = 6,
  parameter int DEAD_CYC = 80,
  localparam int CIW = $clog2(N_CLASS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IN-1:0]    l0_in,
  input  logic [N_CLUST-1:0] clust_busy,
  input  logic [N_CLUST-1:0] pf_reject,
  input  logic               cfg_we,
  input  logic [CIW-1:0]     cfg_addr,
  input  logic [1:0]         cfg_sel,
  input  logic [N_IN-1:0]    cfg_wdata,
  output logic [N_CLASS-1:0] class_fired,
  output logic [N_CLUST-1:0] clust_l0
);
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  logic [N_CLASS-1:0]              match;
  logic [N_CLASS-1:0][N_CLUST-1:0] route;
  logic [N_CLUST-1:0]              dead, allow, l0_d;
  logic [N_CLASS-1:0]              fired_d;
  logic                            any_dead, wr_ok;

  assign wr_ok = cfg_we && !any_dead;

  l0cg_class_table #(.N_IN(N_IN), .N_CLASS(N_CLASS), .N_CLUST(N_CLUST)) u_tab (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_ok), .wr_addr(cfg_addr),
    .wr_sel(cfg_sel_e'(cfg_sel)), .wr_data(cfg_wdata), .trig_in(l0_in),
    .match(match), .route(route)
  );

  l0cg_deadtime #(.N_CLUST(N_CLUST), .DEAD_CYC(DEAD_CYC)) u_dead (
    .clk(clk), .rst_n(rst_i), .fire(l0_d), .dead(dead), .any_dead(any_dead)
  );

  assign allow = ~(clust_busy | pf_reject | dead);

  always_comb begin
    l0_d = '0;
    for (int i = 0; i < N_CLASS; i++) begin
      fired_d[i] = match[i] && ((route[i] & allow) != '0);
      l0_d       = l0_d | (route[i] & {N_CLUST{fired_d[i]}});
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      class_fired <= '0;
      clust_l0    <= '0;
    end else begin
      class_fired <= fired_d;
      clust_l0    <= l0_d;
    end
  end

  for (genvar c = 0; c < N_CLUST; c++) begin : g_chk
    p_busy_blocks_r4: assert property (@(posedge clk) disable iff (!rst_i)
      clust_busy[c] |=> !clust_l0[c]);
    p_pf_blocks_r5: assert property (@(posedge clk) disable iff (!rst_i)
      pf_reject[c] |=> !clust_l0[c]);
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_i)
      clust_l0[c] |=> !clust_l0[c]);
  end

  // R6: any fired class must be accompanied by a cluster pulse
  p_fired_has_pulse_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (class_fired != '0) |-> (clust_l0 != '0));
endmodule

// File: tb/l0_class_gate_test.sv
module l0_class_gate_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] l0_in;
  logic [5:0]  clust_busy, pf_reject;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [1:0]  cfg_sel;
  logic [23:0] cfg_wdata;
  logic [49:0] class_fired;
  logic [5:0]  clust_l0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  l0_class_gate uut (
    .clk(clk), .rst_n(rst_n), .l0_in(l0_in), .clust_busy(clust_busy),
    .pf_reject(pf_reject), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .class_fired(class_fired), .clust_l0(clust_l0)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      l0_in = '0; clust_busy = '0; pf_reject = '0; cfg_we = 1'b0;
    end
  endtask

  task automatic wr(int cls, int sel, logic [23:0] d);
    @(negedge clk);
    l0_in = '0;
    cfg_we = 1'b1; cfg_addr = 6'(cls); cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one crossing, then read the registered result on the next falling edge
  task automatic apply(logic [23:0] p, logic [5:0] b, logic [5:0] f);
    l0_in = p; clust_busy = b; pf_reject = f;
    @(negedge clk);
    l0_in = '0; clust_busy = '0; pf_reject = '0;
  endtask

  localparam logic [49:0] C0 = 50'd1 << 0, C1 = 50'd1 << 1, C2 = 50'd1 << 2,
                          C49 = 50'd1 << 49;

  task automatic t_reset;
    chk("R1 fired after reset", 64'(class_fired), 64'd0);
    chk("R1 pulse after reset", 64'(clust_l0), 64'd0);
    apply('1, '0, '0);
    chk("R1 all-ones with empty table", 64'(class_fired), 64'd0);
  endtask

  task automatic t_setup;
    wr(0, 0, 24'h000001); wr(0, 2, 24'd0);
    wr(1, 0, 24'h000002); wr(1, 1, 24'h000004); wr(1, 2, 24'd1);
    wr(2, 0, 24'h000001); wr(2, 2, 24'd0);
    wr(3, 0, 24'h000020); wr(3, 2, 24'd7);
    wr(49, 0, 24'h800000); wr(49, 2, 24'd5);
    wr(10, 3, 24'hFFFFFF);
    idle(2);
  endtask

  task automatic t_match;
    apply(24'h000002, '0, '0);
    chk("R2 class1 required bit", 64'(class_fired), 64'(C1));
    chk("R2 cluster1 pulse", 64'(clust_l0), 64'h02);
    idle(85);
    apply(24'h000006, '0, '0);
    chk("R2 forbidden bit blocks class1", 64'(class_fired), 64'd0);
    apply(24'h800000, '0, '0);
    chk("R2 class49 to cluster5", 64'(clust_l0), 64'h20);
    idle(85);
  endtask

  task automatic t_or;
    apply(24'h000001, '0, '0);
    chk("R6 two classes fire", 64'(class_fired), 64'(C0 | C2));
    chk("R6 cluster0 OR pulse", 64'(clust_l0), 64'h01);
    @(negedge clk);
    chk("R6 pulse one cycle", 64'(clust_l0), 64'h00);
    idle(85);
  endtask

  task automatic t_disabled;
    apply('1, '0, '0);
    chk("R3 class10 empty never fires", 64'(class_fired[10]), 64'd0);
    chk("R3 all-ones vector", 64'(class_fired), 64'(C0 | C2 | C49));
    idle(85);
    apply(24'h000020, '0, '0);
    chk("R10 invalid cluster class3", 64'(class_fired), 64'd0);
    chk("R10 no pulse", 64'(clust_l0), 64'd0);
  endtask

  task automatic t_veto;
    apply(24'h000003, 6'h01, '0);
    chk("R4 busy cluster0 blocks", 64'(class_fired), 64'(C1));
    chk("R4 cluster1 unaffected", 64'(clust_l0), 64'h02);
    idle(85);
    apply(24'h000003, '0, 6'h02);
    chk("R5 pf cluster1 blocks", 64'(class_fired), 64'(C0 | C2));
    chk("R5 cluster0 still pulses", 64'(clust_l0), 64'h01);
    idle(85);
  endtask

  task automatic t_dead;
    for (int k = 0; k <= 80; k++) begin
      l0_in = 24'h000001 | ((k == 5) ? 24'h000002 : 24'h0);
      @(negedge clk);
      chk((k == 5) ? "R8 other cluster during dead" : "R7 dead-time spacing",
          64'(clust_l0),
          64'(((k == 0 || k == 80) ? 6'h01 : 6'h00) | ((k == 5) ? 6'h02 : 6'h00)));
    end
    l0_in = '0;
    idle(85);
  endtask

  task automatic t_cfg;
    apply(24'h000001, '0, '0);
    wr(0, 0, 24'h000010);
    idle(85);
    apply(24'h000001, '0, '0);
    chk("R9 write during dead ignored", 64'(class_fired), 64'(C0 | C2));
    idle(85);
    wr(0, 0, 24'h000010);
    idle(1);
    apply(24'h000010, '0, '0);
    chk("R9 idle write applied", 64'(class_fired), 64'(C0));
    idle(85);
    apply(24'h000001, '0, '0);
    chk("R9 old mask gone", 64'(class_fired), 64'(C2));
    idle(85);
  endtask

  initial begin
    rst_n = 1'b0; l0_in = '0; clust_busy = '0; pf_reject = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_setup;
    t_match;
    t_or;
    t_disabled;
    t_veto;
    t_dead;
    t_cfg;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule